// File: doc/BRIEF.md
# Serial video link scrambler and NRZI encoder

This block takes 10-bit words, which the word interleaver ahead of it has already formed, and turns them into the single bit stream for a high-definition serial video link. It runs on the serial bit clock, so at 1.485 Gb/s the words arrive at one tenth of that rate. A one-clock word strobe loads each word, and the block then shifts the word out one bit per clock, least significant bit first. Strobes come every ten clocks with no gap between words.

Each serial bit first goes through a self-synchronizing scrambler with the generator x^9 + x^4 + 1, which pseudo-randomizes the data and keeps the DC content of the line low. It then goes through an x + 1 NRZI stage, which turns long runs of ones into transitions, so the receiver does not care about the polarity of the link. When the single bypass input is high, both stages are switched off and the raw serialized bit drives the output. Their internal state is held while bypass is high. A receiver recovers the data with the inverse operations. Because the scrambler is self-synchronizing, the receiver locks within nine bits from any starting state.

Top module: `vlink_serial_enc`

## Requirements
- R1: While reset is asserted, `bit_out` is 0. Reset clears the word shifter, the nine-bit scrambler history and the NRZI state to all zeros. Reset asserts asynchronously and is released on the clock. After `rst_n` rises, the block acts from the third rising edge onwards.
- R2: When `word_ld` is high at a rising edge, `word_in` is captured. The serial bit for `word_in[k]` (k = 0 first) is the one processed at the (k+1)-th rising edge after the load. `bit_out` shows the result of processing bit k from that edge until the next edge, so there is one clock of latency.
- R3: Loads on every tenth rising edge give a continuous bit stream with no gap between words. The bit for `word_in[0]` of the next word follows straight after the bit for `word_in[9]` of the previous word.
- R4: When bypass is low, the scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9]. Here d[n] is the serial input bit, and s[] counts only the clocks in which bypass was low.
- R5: When bypass is low, the NRZI bit is t[n] = s[n] XOR t[n-1], with t starting at 0, and `bit_out` shows t[n].
- R6: When bypass is high at an edge, `bit_out` becomes the raw serial bit processed at that edge.
- R7: When bypass is high at an edge, the scrambler history and the NRZI state do not change. Encoding resumes from the held state when bypass returns low.
- R8: Once a word's ten bits are used and no new load has come, the serial input bit is 0. These zeros are scrambled and NRZI-encoded like any other data bits.
- R9: The inverse operations recover the serial input bits exactly from `bit_out`. These are d[n] = s[n] XOR s[n-4] XOR s[n-9], with s[n] = t[n] XOR t[n-1], applied over the non-bypassed clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial bit clock, one cycle per output bit |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| word_ld | input | 1 | Word strobe; loads `word_in` at the rising edge where it is high |
| word_in | input | WORD_W (10) | Interleaved parallel word, bit 0 sent first |
| bypass | input | 1 | High: send raw serial bits and freeze the scrambler and NRZI state |
| bit_out | output | 1 | Registered serial output bit |

## Verification
The hardest case to set up from the ports is bypass toggling in the middle of a word while the scrambler history holds non-zero data. Only then does a failure to freeze the nine-bit history, or the NRZI state, show up later as a wrong output. The stimulus gets there in three steps. It first runs pseudo-random words through the encoder, so the history is dense. It then drives a per-bit bypass mask inside individual words. Finally it lets the encoder run on with idle zero input, so any corrupted history shows up at the output. A receiver model in the bench decodes the output on every non-bypassed clock and compares the result with the raw bits. This round-trip check runs across long runs of ones and zeros, mid-stream resets and gaps between words.

// File: rtl/vlink_pkg.sv
package vlink_pkg;
  // Parallel word width delivered by the interleaver.
  localparam int WORD_W  = 10;
  // Scrambler generator x^SCR_LEN + x^SCR_TAP + 1.
  localparam int SCR_LEN = 9;
  localparam int SCR_TAP = 4;
  // Flops in the reset release synchronizer.
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/vlink_rst_sync.sv
module vlink_rst_sync #(
  parameter int STAGES = vlink_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/vlink_word_shifter.sv
module vlink_word_shifter #(
  parameter int WORD_W = vlink_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] word_d;

  // A load replaces the contents; otherwise shift right, filling with 0.
  always_comb begin
    if (load) begin
      word_d = word;
    end else begin
      word_d = {1'b0, word_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/vlink_scrambler.sv
module vlink_scrambler #(
  parameter int SCR_LEN = vlink_pkg::SCR_LEN,
  parameter int SCR_TAP = vlink_pkg::SCR_TAP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               din,
  output logic               dout,
  output logic [SCR_LEN-1:0] hist_q
);
  // hist_q[k] holds the scrambled bit from k+1 active clocks ago.
  logic [SCR_LEN-1:0] hist_d;

  assign dout = din ^ hist_q[SCR_TAP-1] ^ hist_q[SCR_LEN-1];

  assign hist_d[0] = en ? dout : hist_q[0];
  for (genvar k = 1; k < SCR_LEN; k++) begin : g_hist
    assign hist_d[k] = en ? hist_q[k-1] : hist_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/vlink_nrzi.sv
module vlink_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout_d,
  output logic state_q
);
  logic state_d;

  assign dout_d = din ^ state_q;

  always_comb begin
    state_d = state_q;
    if (en) begin
      state_d = dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/vlink_serial_enc.sv
module vlink_serial_enc #(
  parameter int WORD_W  = vlink_pkg::WORD_W,
  parameter int SCR_LEN = vlink_pkg::SCR_LEN,
  parameter int SCR_TAP = vlink_pkg::SCR_TAP
) (
  input  logic              clk_ser,
  input  logic              rst_n,
  input  logic              word_ld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              bypass,
  output logic              bit_out
);
  logic               rst_sync_n;
  logic [WORD_W-1:0]  sh_word;
  logic               raw_bit;
  logic               stage_en;
  logic               scr_bit;
  logic [SCR_LEN-1:0] scr_hist;
  logic               nrzi_d;
  logic               nrzi_q;
  logic               out_d;
  logic               out_q;

  vlink_rst_sync u_rst_sync (
    .clk        (clk_ser),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vlink_word_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk    (clk_ser),
    .rst_n  (rst_sync_n),
    .load   (word_ld),
    .word   (word_in),
    .word_q (sh_word)
  );

  assign raw_bit  = sh_word[0];
  assign stage_en = ~bypass;

  vlink_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scrambler (
    .clk    (clk_ser),
    .rst_n  (rst_sync_n),
    .en     (stage_en),
    .din    (raw_bit),
    .dout   (scr_bit),
    .hist_q (scr_hist)
  );

  vlink_nrzi u_nrzi (
    .clk     (clk_ser),
    .rst_n   (rst_sync_n),
    .en      (stage_en),
    .din     (scr_bit),
    .dout_d  (nrzi_d),
    .state_q (nrzi_q)
  );

  always_comb begin
    out_d = bypass ? raw_bit : nrzi_d;
  end

  always_ff @(posedge clk_ser or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign bit_out = out_q;
endmodule

// File: rtl/vlink_serial_enc_chk.sv
module vlink_serial_enc_chk #(
  parameter int WORD_W  = 10,
  parameter int SCR_LEN = 9
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               word_ld,
  input logic [WORD_W-1:0]  word_in,
  input logic               bypass,
  input logic               bit_out,
  input logic [WORD_W-1:0]  sh_word,
  input logic               scr_bit,
  input logic [SCR_LEN-1:0] scr_hist,
  input logic               nrzi_q
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_sync_n === 1'b0) begin
      assert_reset_quiet_R1: assert (bit_out == 1'b0 && nrzi_q == 1'b0 && scr_hist == '0);
    end
  end

  assert_shift_load_R2: assert property (@(posedge clk) disable iff (!armed_q)
    $past(word_ld) |-> sh_word == $past(word_in));

  assert_shift_zero_fill_R8: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(word_ld) |-> sh_word == ($past(sh_word) >> 1));

  assert_scr_history_R4: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(bypass) |-> scr_hist == {$past(scr_hist[SCR_LEN-2:0]), $past(scr_bit)});

  assert_nrzi_step_R5: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(bypass) |-> (nrzi_q == ($past(scr_bit) ^ $past(nrzi_q))) && (bit_out == nrzi_q));

  assert_bypass_raw_R6: assert property (@(posedge clk) disable iff (!armed_q)
    $past(bypass) |-> bit_out == $past(sh_word[0]));

  assert_bypass_hold_R7: assert property (@(posedge clk) disable iff (!armed_q)
    $past(bypass) |-> $stable(scr_hist) && $stable(nrzi_q));
endmodule

bind vlink_serial_enc vlink_serial_enc_chk #(.WORD_W(WORD_W), .SCR_LEN(SCR_LEN)) i_chk (
  .clk        (clk_ser),
  .rst_sync_n (rst_sync_n),
  .word_ld    (word_ld),
  .word_in    (word_in),
  .bypass     (bypass),
  .bit_out    (bit_out),
  .sh_word    (sh_word),
  .scr_bit    (scr_bit),
  .scr_hist   (scr_hist),
  .nrzi_q     (nrzi_q)
);

// File: tb/test_vlink_serial_enc.sv
module test_vlink_serial_enc;
  localparam int CLK_P = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic       clk_ser = 1'b0;
  logic       rst_n   = 1'b1;
  logic       word_ld = 1'b0;
  logic [9:0] word_in = '0;
  logic       bypass  = 1'b0;
  logic       bit_out;

  vlink_serial_enc i_vlink_serial_enc (
    .clk_ser (clk_ser),
    .rst_n   (rst_n),
    .word_ld (word_ld),
    .word_in (word_in),
    .bypass  (bypass),
    .bit_out (bit_out)
  );

  always #(CLK_P/2) clk_ser = ~clk_ser;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R8";
  bit    done     = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Transmit-side model: pending raw bits, scrambled history, line state.
  int q_bits[$];
  int cur_bit   = 0;
  int scr_hist[$] = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
  int line_lvl  = 0;
  int exp_out   = 0;
  int exp_raw   = 0;
  int exp_byp   = 1;

  always @(posedge clk_ser) begin
    int s;
    if (!rst_n) begin
      q_bits.delete();
      cur_bit  = 0;
      scr_hist = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
      line_lvl = 0;
      exp_out  = 0;
      exp_byp  = 1;
    end else begin
      exp_raw = cur_bit;
      if (bypass) begin
        exp_out = cur_bit;
        exp_byp = 1;
      end else begin
        s = cur_bit ^ scr_hist[3] ^ scr_hist[8];
        scr_hist.push_front(s);
        void'(scr_hist.pop_back());
        line_lvl = line_lvl ^ s;
        exp_out  = line_lvl;
        exp_byp  = 0;
      end
      if (word_ld) begin
        q_bits.delete();
        cur_bit = int'(word_in[0]);
        for (int i = 1; i < 10; i++) q_bits.push_back(int'(word_in[i]));
      end else if (q_bits.size() > 0) begin
        cur_bit = q_bits.pop_front();
      end else begin
        cur_bit = 0;
      end
    end
  end

  // Receive-side model: undo NRZI, then descramble.
  int rx_prev = 0;
  int rx_hist[$] = '{0, 0, 0, 0, 0, 0, 0, 0, 0};

  always @(negedge clk_ser) begin
    int s;
    int d;
    if (!done) begin
      if (!rst_n) begin
        check(bit_out === 1'b0, "R1", int'(bit_out), 0);
        rx_prev = 0;
        rx_hist = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
      end else begin
        check(bit_out === exp_out[0], cur_req, int'(bit_out), exp_out);
        if (exp_byp == 0) begin
          s = int'(bit_out) ^ rx_prev;
          rx_prev = int'(bit_out);
          d = s ^ rx_hist[3] ^ rx_hist[8];
          rx_hist.push_front(s);
          void'(rx_hist.pop_back());
          check(d == exp_raw, "R9", d, exp_raw);
        end
      end
    end
  end

  // One word over ten clocks; bmask[k] is the bypass level for the k-th edge.
  task automatic send(input logic [9:0] w, input logic [9:0] bmask);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_ser);
      word_ld = (k == 0);
      word_in = (k == 0) ? w : 10'h000;
      bypass  = bmask[k];
    end
  endtask

  task automatic idle(input int n, input logic byp);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_ser);
      word_ld = 1'b0;
      bypass  = byp;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * WATCHDOG_CYC);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [9:0] prng;
    prng = 10'h1A7;
    #1 rst_n = 1'b0;
    cur_req = "R1";
    idle(5, 1'b0);
    @(negedge clk_ser) rst_n = 1'b1;

    // R8: idle zeros after reset give a quiet line.
    cur_req = "R8";
    idle(12, 1'b0);

    // R2 / R6: bypassed words appear raw, LSB first, one clock late.
    cur_req = "R6";
    send(10'h2B5, 10'h3FF);
    cur_req = "R2";
    send(10'h3FF, 10'h3FF);
    send(10'h001, 10'h3FF);
    send(10'h200, 10'h3FF);

    // R4 / R5 / R3: scrambled, NRZI-coded, gapless pseudo-random words.
    cur_req = "R4";
    for (int i = 0; i < 30; i++) begin
      prng = {prng[8:0], prng[9] ^ prng[6]} ^ 10'(i * 37);
      send(prng, 10'h000);
    end
    cur_req = "R5";
    for (int i = 0; i < 10; i++) send(10'h3FF, 10'h000);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) send(10'h000, 10'h000);
    for (int i = 0; i < 10; i++) send(10'h155, 10'h000);
    for (int i = 0; i < 10; i++) send(10'(i * 93 + 5), 10'h000);

    // R7: bypass toggled inside words with a busy scrambler history.
    cur_req = "R7";
    send(10'h3A5, 10'b0000111000);
    send(10'h0F3, 10'b1100000011);
    send(10'h2DB, 10'b0101010101);
    send(10'h3FF, 10'b0000000001);
    for (int i = 0; i < 6; i++) send(10'(i * 171 + 11), 10'h000);

    // R8: strobe withheld; zeros keep flowing through a non-zero history.
    cur_req = "R8";
    idle(40, 1'b0);
    send(10'h1C3, 10'h000);
    idle(7, 1'b1);
    idle(20, 1'b0);

    // R1: reset in the middle of a word, then resume.
    send(10'h2F0, 10'h000);
    cur_req = "R1";
    word_ld = 1'b0;
    rst_n   = 1'b0;
    idle(4, 1'b0);
    @(negedge clk_ser) rst_n = 1'b1;
    idle(6, 1'b0);
    cur_req = "R3";
    for (int i = 0; i < 8; i++) send(10'(i * 211 + 77), 10'h000);
    idle(12, 1'b0);

    finish_run();
  end
endmodule